// File: doc/BRIEF.md
# Data Trace Message Encoder

This block sits between a processor's data-access observation point and a debug trace port. Each cycle in which a bus access is observed (strobe, address, data, size and a read/write flag) while data trace is switched on, it produces one packed, variable-length trace message one clock later, together with a valid bit and the message length in bits. The queue that holds messages and the serializer that moves them off chip are outside this block.

To keep messages short, the address is normally sent in compressed form: only the bits that differ from the address of the previously sent message, with leading zeros trimmed. A set of conditions (leaving reset, leaving a low-power or debug state, switching trace on, a run of 255 compressed messages, an event input, a watchpoint hit, a queue overrun) makes the next message a synchronization message, which carries the full address (leading zeros trimmed) so that a tool can recover the absolute address. Such a condition arriving in a cycle with no message is held until the next message goes out; one arriving in the same cycle as an access applies to that access.

Top module: `dtrace_msg_enc`

## Requirements
- R1: Message bit layout, LSB first: bits [5:0] carry the transfer code (compressed read = 6, compressed write = 5, sync read = 14, sync write = 13); the address field of n bits starts at bit 6; the data field starts at bit 6+n and is 8, 16, 24 or 32 bits wide for size codes 00, 01, 10, 11, holding the low bits of the access data.
- R2: The length output equals 6 + n + data width, so it ranges from 15 to 63, and every message bit at or above the length is zero.
- R3: In a compressed message the address field is the XOR of the current address and the address of the previous message; n is the index of its highest set bit plus one, and at least 1 when the addresses are equal.
- R4: In a sync message the address field is the full access address, with n the index of its highest set bit plus one (at least 1).
- R5: The first message after reset is a sync message.
- R6: A one-cycle pulse on the low-power-exit input or on the debug-exit input makes the next message a sync message.
- R7: Accesses while the trace-enable input is low produce no message and leave the reference address unchanged; the first message after trace-enable rises is a sync message.
- R8: After 255 compressed messages in a row, the next message is a sync message; any sync message restarts that count.
- R9: A rising edge on the event input while the 2-bit event control field is 00 makes the next message a sync message; with any other control value the edge has no effect.
- R10: A watchpoint-hit pulse or a queue-overrun pulse makes the next message a sync message.
- R11: A message appears on the outputs exactly one cycle after the accepted access; every message, of either kind, makes its address the new reference; the outputs are zero after reset.
- R12: A sync condition seen in a cycle with no message is held until the next message, which is then a sync message, and only that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Observed data access strobe |
| acc_addr | input | 25 | Access address |
| acc_data | input | 32 | Access data, low bits used per size |
| acc_size | input | 2 | Access size code (00=8 .. 11=32 bits) |
| acc_read | input | 1 | 1 = read, 0 = write |
| trace_en | input | 1 | Data trace enable level |
| lowpwr_exit | input | 1 | Pulse on leaving a low-power mode |
| dbg_exit | input | 1 | Pulse on leaving debug mode |
| evt_in | input | 1 | Event input level |
| evt_ctrl | input | 2 | Event control field; 00 enables resync on event |
| wpt_hit | input | 1 | Watchpoint hit pulse |
| q_overrun | input | 1 | Queue overrun pulse |
| msg_valid | output | 1 | Message present this cycle |
| msg_bits | output | 63 | Packed message, LSB first |
| msg_len | output | 6 | Message length in bits |

## Verification
The assertions take for granted that the low-power-exit, debug-exit, watchpoint and overrun inputs are single-cycle pulses, that the event input is a level whose rising edge matters, and that address and data never exceed their port widths. The stimulus keeps to this by raising each pulse for exactly one cycle and only rarely, holding the event input for random stretches while varying the control field, and toggling trace enable seldom so that long runs of compressed messages still occur. Directed cases cover equal addresses, a top-bit address change with a full-width data field, held conditions and the 255-message boundary.

// File: rtl/dtm_pkg.sv
// Shared codes and helpers for the data trace message encoder.
// Assumes the transfer code field is 6 bits wide at the bottom of each message.
package dtm_pkg;
    localparam int TC_W = 6;

    typedef enum logic [TC_W-1:0] {
        TC_WRITE      = 6'd5,
        TC_READ       = 6'd6,
        TC_SYNC_WRITE = 6'd13,
        TC_SYNC_READ  = 6'd14
    } tcode_e;

    // Select the transfer code from message kind and direction.
    function automatic tcode_e pick_code(input logic sync, input logic rd);
        if (sync) return rd ? TC_SYNC_READ : TC_SYNC_WRITE;
        return rd ? TC_READ : TC_WRITE;
    endfunction
endpackage

// File: rtl/dtm_sync_ctrl.sv
// Tracks every condition that forces a synchronization message.
// Assumes lowpwr_exit, dbg_exit, wpt_hit and q_overrun are one-cycle pulses;
// trace_en and evt_in are levels whose rising edges are detected here.
// A condition seen in the same cycle as a fired message applies to it.
module dtm_sync_ctrl #(
    parameter int CNT_LIMIT = 255,
    localparam int CNT_W = $clog2(CNT_LIMIT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       trace_en,
    input  logic       lowpwr_exit,
    input  logic       dbg_exit,
    input  logic       evt_in,
    input  logic [1:0] evt_ctrl,
    input  logic       wpt_hit,
    input  logic       q_overrun,
    output logic       sync_now
);
    logic             pend_q;
    logic [CNT_W-1:0] rel_cnt_q;
    logic             ten_q;
    logic             evt_q;
    logic             force_now;

    // Combine the cycle's own resync causes with held state.
    always_comb begin
        force_now = lowpwr_exit | dbg_exit | wpt_hit | q_overrun
                  | (trace_en & ~ten_q)
                  | (evt_in & ~evt_q & (evt_ctrl == 2'b00));
        sync_now  = pend_q | force_now | (rel_cnt_q == CNT_W'(CNT_LIMIT));
    end

    // Hold pending resync, count compressed messages, sample level inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b1;
            rel_cnt_q <= '0;
            ten_q     <= 1'b0;
            evt_q     <= 1'b0;
        end else begin
            ten_q <= trace_en;
            evt_q <= evt_in;
            if (fire) begin
                pend_q    <= 1'b0;
                rel_cnt_q <= sync_now ? '0 : rel_cnt_q + 1'b1;
            end else begin
                pend_q <= pend_q | force_now;
            end
        end
    end
endmodule

// File: rtl/dtm_field_sel.sv
// Chooses the address field value and its trimmed width.
// Compressed: XOR against the previous message address; sync: full address.
// Width is the highest set bit index plus one, never below one.
module dtm_field_sel #(
    parameter int ADDR_W = 25,
    localparam int NW = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] prev_addr,
    input  logic              sync,
    output logic [ADDR_W-1:0] field_val,
    output logic [NW-1:0]     field_len
);
    // Form the field and find its leading set bit.
    always_comb begin
        field_val = sync ? cur_addr : (cur_addr ^ prev_addr);
        field_len = NW'(1);
        for (int i = 1; i < ADDR_W; i++) begin
            if (field_val[i]) field_len = NW'(i + 1);
        end
    end
endmodule

// File: rtl/dtm_packer.sv
// Packs code, address field and sized data into one registered message.
// Assumes field_val carries no set bits at or above field_len.
module dtm_packer #(
    parameter int ADDR_W = 25,
    parameter int DATA_W = 32,
    localparam int MSG_W = dtm_pkg::TC_W + ADDR_W + DATA_W,
    localparam int LEN_W = $clog2(MSG_W + 1),
    localparam int NW    = $clog2(ADDR_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  dtm_pkg::tcode_e         code,
    input  logic [ADDR_W-1:0]       field_val,
    input  logic [NW-1:0]           field_len,
    input  logic [DATA_W-1:0]       data,
    input  logic [1:0]              size,
    output logic                    msg_valid,
    output logic [MSG_W-1:0]        msg_bits,
    output logic [LEN_W-1:0]        msg_len
);
    logic [LEN_W-1:0]  data_w;
    logic [DATA_W-1:0] data_m;
    logic [MSG_W-1:0]  body;
    logic [LEN_W-1:0]  body_len;

    // Size the data field, clear unused data bits and assemble the message.
    always_comb begin
        data_w = LEN_W'((int'(size) + 1) * 8);
        for (int i = 0; i < DATA_W; i++) begin
            data_m[i] = data[i] & (i < int'(data_w));
        end
        body = MSG_W'(code)
             | (MSG_W'(field_val) << dtm_pkg::TC_W)
             | (MSG_W'(data_m) << (dtm_pkg::TC_W + int'(field_len)));
        body_len = LEN_W'(dtm_pkg::TC_W) + LEN_W'(field_len) + data_w;
    end

    // Register the message one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_bits  <= '0;
            msg_len   <= '0;
        end else begin
            msg_valid <= fire;
            msg_bits  <= fire ? body : '0;
            msg_len   <= fire ? body_len : '0;
        end
    end
endmodule

// File: rtl/dtrace_msg_enc.sv
// Data trace message encoder top: compressed or sync message per access.
// Assumes one access per cycle at most and the sync causes described in
// dtm_sync_ctrl. The reference address reloads on every emitted message.
module dtrace_msg_enc #(
    parameter int ADDR_W    = 25,
    parameter int DATA_W    = 32,
    parameter int CNT_LIMIT = 255,
    localparam int MSG_W = dtm_pkg::TC_W + ADDR_W + DATA_W,
    localparam int LEN_W = $clog2(MSG_W + 1),
    localparam int NW    = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic [1:0]        acc_size,
    input  logic              acc_read,
    input  logic              trace_en,
    input  logic              lowpwr_exit,
    input  logic              dbg_exit,
    input  logic              evt_in,
    input  logic [1:0]        evt_ctrl,
    input  logic              wpt_hit,
    input  logic              q_overrun,
    output logic              msg_valid,
    output logic [MSG_W-1:0]  msg_bits,
    output logic [LEN_W-1:0]  msg_len
);
    logic              fire;
    logic              sync_now;
    logic [ADDR_W-1:0] prev_addr_q;
    logic [ADDR_W-1:0] field_val;
    logic [NW-1:0]     field_len;
    dtm_pkg::tcode_e   code;

    // Accept an access only while trace is on; pick its code.
    always_comb begin
        fire = acc_valid & trace_en;
        code = dtm_pkg::pick_code(sync_now, acc_read);
    end

    // Keep the address of the last emitted message as reference.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_addr_q <= '0;
        else if (fire) prev_addr_q <= acc_addr;
    end

    dtm_sync_ctrl #(.CNT_LIMIT(CNT_LIMIT)) u_sync (
        .clk(clk), .rst_n(rst_n), .fire(fire), .trace_en(trace_en),
        .lowpwr_exit(lowpwr_exit), .dbg_exit(dbg_exit), .evt_in(evt_in),
        .evt_ctrl(evt_ctrl), .wpt_hit(wpt_hit), .q_overrun(q_overrun),
        .sync_now(sync_now)
    );

    dtm_field_sel #(.ADDR_W(ADDR_W)) u_field (
        .cur_addr(acc_addr), .prev_addr(prev_addr_q), .sync(sync_now),
        .field_val(field_val), .field_len(field_len)
    );

    dtm_packer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .fire(fire), .code(code),
        .field_val(field_val), .field_len(field_len), .data(acc_data),
        .size(acc_size), .msg_valid(msg_valid), .msg_bits(msg_bits),
        .msg_len(msg_len)
    );
endmodule

// File: rtl/dtm_checker.sv
// Port-level properties of the data trace message encoder.
// Assumes single-cycle pulses on the resync inputs (see the brief).
module dtm_checker #(
    parameter int MSG_W     = 63,
    parameter int LEN_W     = 6,
    parameter int CNT_LIMIT = 255
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             trace_en,
    input logic             wpt_hit,
    input logic             msg_valid,
    input logic [MSG_W-1:0] msg_bits,
    input logic [LEN_W-1:0] msg_len
);
    localparam int CW = $clog2(CNT_LIMIT + 1) + 1;
    logic          seen_q;
    logic [CW-1:0] rel_seen_q;
    logic          is_sync;

    assign is_sync = (msg_bits[5:0] == 6'd13) || (msg_bits[5:0] == 6'd14);

    // Track whether any message appeared and the compressed run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            rel_seen_q <= '0;
        end else if (msg_valid) begin
            seen_q     <= 1'b1;
            rel_seen_q <= is_sync ? '0 : rel_seen_q + 1'b1;
        end
    end

    p_code_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_bits[5:0] inside {6'd5, 6'd6, 6'd13, 6'd14}));
    p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_len >= LEN_W'(15) && msg_len <= LEN_W'(MSG_W)));
    p_clean_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((msg_bits >> msg_len) == '0));
    p_first_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !seen_q) |-> is_sync);
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> !msg_valid);
    p_run_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && rel_seen_q >= CW'(CNT_LIMIT)) |-> is_sync);
    p_wpt_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wpt_hit && acc_valid && trace_en) |=> (msg_valid && is_sync));
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && trace_en) |=> msg_valid);
endmodule

bind dtrace_msg_enc dtm_checker #(
    .MSG_W(MSG_W), .LEN_W(LEN_W), .CNT_LIMIT(CNT_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .trace_en(trace_en),
    .wpt_hit(wpt_hit), .msg_valid(msg_valid), .msg_bits(msg_bits),
    .msg_len(msg_len)
);

// File: tb/tb_dtrace_msg_enc.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module tb_dtrace_msg_enc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [24:0] acc_addr = '0;
    logic [31:0] acc_data = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_read = 1'b0;
    logic        ten = 1'b0, lp = 1'b0, dbg = 1'b0, evt = 1'b0, wpt = 1'b0, ovr = 1'b0;
    logic [1:0]  ctrl = 2'b00;
    logic        msg_valid;
    logic [62:0] msg_bits;
    logic [5:0]  msg_len;

    int total = 0, bad = 0;
    bit finished = 0;

    // Reference model state.
    logic [24:0] m_ref = '0;
    bit          m_pend = 1;
    int          m_cnt = 0;
    bit          m_ten_q = 0, m_evt_q = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtrace_msg_enc dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_data(acc_data), .acc_size(acc_size), .acc_read(acc_read),
        .trace_en(ten), .lowpwr_exit(lp), .dbg_exit(dbg), .evt_in(evt),
        .evt_ctrl(ctrl), .wpt_hit(wpt), .q_overrun(ovr),
        .msg_valid(msg_valid), .msg_bits(msg_bits), .msg_len(msg_len)
    );

    // Build an expected message from the requirement text.
    function automatic void enc(input bit s, input bit rd, input logic [24:0] val,
                                input logic [31:0] d, input logic [1:0] sz,
                                output logic [62:0] m, output int len);
        int n = 1;
        int dw = 8 * (int'(sz) + 1);
        int code = s ? (rd ? 14 : 13) : (rd ? 6 : 5);
        for (int i = 0; i < 25; i++) if (val[i]) n = i + 1;
        m = '0;
        for (int i = 0; i < 6; i++) m[i] = code[i];
        for (int i = 0; i < n; i++) m[6 + i] = val[i];
        for (int i = 0; i < dw; i++) m[6 + n + i] = d[i];
        len = 6 + n + dw;
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, predict, check after the next rising edge.
    task automatic step(input bit v, input logic [24:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input bit rd, input string tag);
        bit frc, s, fire;
        logic [62:0] em;
        int el;
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_data = d; acc_size = sz; acc_read = rd;
        frc = lp | dbg | wpt | ovr | (ten & ~m_ten_q) | (evt & ~m_evt_q & (ctrl == 2'b00));
        s = m_pend | frc | (m_cnt == 255);
        fire = v & ten;
        em = '0; el = 0;
        if (fire) begin
            enc(s, rd, s ? a : (a ^ m_ref), d, sz, em, el);
            m_ref = a;
            m_pend = 0;
            m_cnt = s ? 0 : m_cnt + 1;
        end else begin
            m_pend = m_pend | frc;
        end
        m_ten_q = ten; m_evt_q = evt;
        @(posedge clk); #1;
        chk(tag, "valid", 64'(msg_valid), 64'(fire));
        if (fire) begin
            chk(tag, "bits", 64'(msg_bits), 64'(em));
            chk(tag, "len", 64'(msg_len), 64'(el));
        end
        lp = 0; dbg = 0; wpt = 0; ovr = 0;
        acc_valid = 0;
    endtask

    task automatic rnd_acc(input string tag);
        logic [24:0] a;
        a = 25'($urandom);
        if ($urandom_range(0, 3) == 0) a = m_ref ^ (25'd1 << $urandom_range(0, 24));
        step(1, a, $urandom, 2'($urandom), 1'($urandom), tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "reset valid", 64'(msg_valid), 0);
        chk("R11", "reset bits", 64'(msg_bits), 0);
        chk("R11", "reset len", 64'(msg_len), 0);
        @(negedge clk); rst_n = 1;

        ten = 1;
        step(1, 25'h000123, 32'hA5, 2'b00, 1, "R5");           // sync read, n=9 (R4)
        chk("R4", "sync code", 64'(msg_bits[5:0]), 14);
        step(1, 25'h000123, 32'h5A, 2'b00, 0, "R3");           // equal addr, n=1, len 15
        chk("R2", "min len", 64'(msg_len), 15);
        step(1, 25'h1000123, 32'hDEADBEEF, 2'b11, 1, "R2");    // top bit differs, len 63
        chk("R2", "max len", 64'(msg_len), 63);
        step(1, 25'h1000120, 32'h1234, 2'b01, 0, "R3");

        ten = 0;
        step(1, 25'h0ABCDE, 32'h1, 2'b00, 1, "R7");
        step(1, 25'h000001, 32'h2, 2'b00, 1, "R7");
        ten = 1;
        step(1, 25'h1000121, 32'h3, 2'b10, 1, "R7");
        chk("R7", "sync after enable", 64'(msg_bits[5:0]), 14);
        step(1, 25'h1000121, 32'h4, 2'b10, 1, "R7");
        chk("R7", "ref kept", 64'(msg_len), 6 + 1 + 24);

        lp = 1;
        step(0, '0, '0, 2'b00, 0, "R12");
        step(0, '0, '0, 2'b00, 0, "R12");
        step(1, 25'h44, 32'h5, 2'b00, 0, "R6");
        chk("R12", "held sync", 64'(msg_bits[5:0]), 13);
        step(1, 25'h44, 32'h5, 2'b00, 0, "R12");
        chk("R12", "only once", 64'(msg_bits[5:0]), 5);
        dbg = 1;
        step(1, 25'h45, 32'h6, 2'b00, 1, "R6");

        ctrl = 2'b01; evt = 1;
        step(1, 25'h46, 32'h7, 2'b00, 1, "R9");
        chk("R9", "ctrl nonzero ignored", 64'(msg_bits[5:0]), 6);
        evt = 0;
        step(1, 25'h47, 32'h7, 2'b00, 1, "R9");
        ctrl = 2'b00; evt = 1;
        step(1, 25'h48, 32'h7, 2'b00, 1, "R9");
        chk("R9", "event sync", 64'(msg_bits[5:0]), 14);
        step(1, 25'h49, 32'h7, 2'b00, 1, "R9");
        evt = 0;

        wpt = 1;
        step(1, 25'h50, 32'h8, 2'b01, 0, "R10");
        ovr = 1;
        step(0, '0, '0, 2'b00, 0, "R10");
        step(1, 25'h51, 32'h9, 2'b01, 0, "R10");

        for (int i = 0; i < 255; i++) rnd_acc("R8");
        step(1, 25'h0F0F0, 32'hC0FFEE, 2'b11, 1, "R8");
        chk("R8", "run limit sync", 64'(msg_bits[5:0]), 14);
        for (int i = 0; i < 254; i++) rnd_acc("R8");
        step(1, 25'h0F0F1, 32'h1, 2'b00, 0, "R8");
        chk("R8", "count restarted", 64'(msg_bits[5:0]), 5);

        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 99) == 0) ten = ~ten;
            if ($urandom_range(0, 15) == 0) evt = ~evt;
            if ($urandom_range(0, 31) == 0) ctrl = 2'($urandom);
            lp  = ($urandom_range(0, 199) == 0);
            dbg = ($urandom_range(0, 199) == 0);
            wpt = ($urandom_range(0, 99) == 0);
            ovr = ($urandom_range(0, 199) == 0);
            if ($urandom_range(0, 3) != 0) rnd_acc("R1");
            else step(0, 25'($urandom), $urandom, 2'($urandom), 1'($urandom), "R1");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule